// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 32-bit memory address for a load/store unit. Each request carries an addressing mode, an operand size and the operands that mode might need: the base register value, the index register value, the global base register value and a displacement field taken from the instruction. The block adds the selected base to the selected offset and returns the address together with a flag that marks a misaligned access or an illegal operand size.

Two of the four modes zero-extend a short displacement and scale it by the operand size before the add. The long-displacement mode adds its 12-bit field as it stands, and the indexed mode adds the index register with no displacement at all. A displacement is never sign-extended. Results are registered behind a valid/ready pair, so a consumer can stall the block and a new request can be taken in the same cycle the previous result leaves.

Top module: `lsu_addr_gen`

## Requirements
- R1: With mode 00 (short displacement) the address is the base register plus the zero-extended low 4 bits of the displacement field, scaled by operand size.
- R2: In modes 00 and 11 the zero-extended displacement is scaled by 1 for size 00 (byte), 2 for size 01 (word) and 4 for size 10 (longword); size 11 uses a scale of 1.
- R3: With mode 01 (long displacement) the address is the base register plus the zero-extended 12-bit displacement field, with no scaling for any size.
- R4: With mode 10 (indexed) the address is the base register plus the index register, and the displacement field has no effect.
- R5: With mode 11 (global base) the address is the global base register plus the zero-extended low 8 bits of the displacement field, scaled by operand size; the base register has no effect.
- R6: A displacement field of all ones gives the largest positive offset of the mode, and displacement bits above the width the mode uses have no effect.
- R7: The sum wraps modulo 2^32 and no overflow is reported.
- R8: Size 11 is illegal and always sets the fault flag.
- R9: The fault flag is set for a word access whose address has bit 0 set and for a longword access whose address has bit 1 or bit 0 set, and is clear for every other legal access.
- R10: in_ready is high when no result is held or the held result is being taken; an accepted request gives out_valid high on the next clock, and a held result stays valid with address and flag unchanged while out_ready is low.
- R11: A synchronous active-high reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | Addressing mode (00 short, 01 long, 10 indexed, 11 global base) |
| in_size | input | 2 | Operand size (00 byte, 01 word, 10 longword, 11 illegal) |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_gbase | input | 32 | Global base register value |
| in_disp | input | 12 | Displacement field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 32 | Effective address |
| out_fault | output | 1 | Misalignment or illegal-size flag |

## Verification
The two functions that share a cycle are the draining of a held result and the acceptance of the next request: when out_valid and out_ready are both high, a waiting request is taken and its address replaces the old one on the following edge with no bubble. The bench provokes this by offering requests back to back while toggling out_ready at random, and its behavioural model, which tracks the held result and the ready rule on its own, is compared with in_ready, out_valid, out_addr and out_fault every cycle, so a lost, repeated or stale result is caught in the cycle it appears.

// File: rtl/lsu_addr_pkg.sv
package lsu_addr_pkg;
  localparam int EA_W   = 32;
  localparam int DISP_W = 12;

  typedef enum logic [1:0] {
    AM_SHORT  = 2'b00,
    AM_LONG   = 2'b01,
    AM_INDEX  = 2'b10,
    AM_GLOBAL = 2'b11
  } am_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } op_size_e;
endpackage

// File: rtl/lsu_addr_offset.sv
module lsu_addr_offset
  import lsu_addr_pkg::*;
#(
  parameter int AW       = EA_W,
  parameter int DW       = DISP_W,
  parameter int SHORT_W  = 4,
  parameter int GLOBAL_W = 8
) (
  input  am_mode_e          mode,
  input  op_size_e          size,
  input  logic [AW-1:0]     base_rn,
  input  logic [AW-1:0]     index_r0,
  input  logic [AW-1:0]     gbase,
  input  logic [DW-1:0]     disp,
  output logic [AW-1:0]     base_sel,
  output logic [AW-1:0]     offset
);
  logic [AW-1:0] short_z, global_z, long_z;
  logic [1:0]    shamt;

  // zero extension of each mode's slice of the displacement field
  assign short_z  = {{(AW-SHORT_W){1'b0}},  disp[SHORT_W-1:0]};
  assign global_z = {{(AW-GLOBAL_W){1'b0}}, disp[GLOBAL_W-1:0]};
  assign long_z   = {{(AW-DW){1'b0}},       disp};

  always_comb begin
    case (size)
      SZ_WORD: shamt = 2'd1;
      SZ_LONG: shamt = 2'd2;
      default: shamt = 2'd0;
    endcase
  end

  always_comb begin
    case (mode)
      AM_SHORT:  begin base_sel = base_rn; offset = short_z << shamt;  end
      AM_LONG:   begin base_sel = base_rn; offset = long_z;            end
      AM_INDEX:  begin base_sel = base_rn; offset = index_r0;          end
      default:   begin base_sel = gbase;   offset = global_z << shamt; end
    endcase
  end
endmodule

// File: rtl/lsu_addr_align.sv
module lsu_addr_align
  import lsu_addr_pkg::*;
#(
  parameter int AW = EA_W
) (
  input  op_size_e      size,
  input  logic [AW-1:0] addr,
  output logic          fault
);
  always_comb begin
    case (size)
      SZ_BYTE: fault = 1'b0;
      SZ_WORD: fault = addr[0];
      SZ_LONG: fault = |addr[1:0];
      default: fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_addr_pkg::*;
#(
  parameter int AW       = EA_W,
  parameter int DW       = DISP_W,
  parameter int SHORT_W  = 4,
  parameter int GLOBAL_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic [1:0]    in_size,
  input  logic [AW-1:0] in_base,
  input  logic [AW-1:0] in_index,
  input  logic [AW-1:0] in_gbase,
  input  logic [DW-1:0] in_disp,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_fault
);
  localparam int SHORT_SPAN  = (1 << SHORT_W) * 4;
  localparam int GLOBAL_SPAN = (1 << GLOBAL_W) * 4;
  localparam int LONG_SPAN   = (1 << DW);

  am_mode_e      mode_e;
  op_size_e      size_e;
  logic [AW-1:0] base_sel, offset, sum;
  logic          fault_c, accept;

  assign mode_e = am_mode_e'(in_mode);
  assign size_e = op_size_e'(in_size);

  lsu_addr_offset #(.AW(AW), .DW(DW), .SHORT_W(SHORT_W), .GLOBAL_W(GLOBAL_W)) u_offset (
    .mode(mode_e), .size(size_e), .base_rn(in_base), .index_r0(in_index),
    .gbase(in_gbase), .disp(in_disp), .base_sel(base_sel), .offset(offset)
  );

  assign sum = base_sel + offset;   // wraps modulo 2^AW

  lsu_addr_align #(.AW(AW)) u_align (.size(size_e), .addr(sum), .fault(fault_c));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_fault <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= sum;
      out_fault <= fault_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_accept_valid_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_fault)));
  assert_illegal_size_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && in_size == 2'b11) |=> out_fault);
  assert_short_span_R1: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == 2'b00) |=> ((out_addr - $past(in_base)) < AW'(SHORT_SPAN)));
  assert_long_span_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == 2'b01) |=> ((out_addr - $past(in_base)) < AW'(LONG_SPAN)));
  assert_index_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == 2'b10) |=> (out_addr == $past(in_base) + $past(in_index)));
  assert_global_span_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == 2'b11) |=> ((out_addr - $past(in_gbase)) < AW'(GLOBAL_SPAN)));
endmodule

// File: tb/lsu_addr_gen_test.sv
`timescale 1ns/1ps
module lsu_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_base = '0, in_index = '0, in_gbase = '0;
  logic [11:0] in_disp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_fault;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    started  = 0;
  bit    finished = 0;
  bit    rnd_ready = 0;
  string cur_tag = "R10";

  // model state
  bit        m_valid = 0;
  bit [31:0] m_addr  = '0;
  bit        m_fault = 0;
  string     m_tag   = "R10";

  always #2 clk = ~clk;

  lsu_addr_gen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_size(in_size), .in_base(in_base),
    .in_index(in_index), .in_gbase(in_gbase), .in_disp(in_disp),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_fault(out_fault)
  );

  function automatic bit [32:0] ref_ea(bit [1:0] m, bit [1:0] s, bit [31:0] rn,
                                       bit [31:0] r0, bit [31:0] gb, bit [11:0] d);
    bit [31:0] a;
    int mult;
    bit f;
    mult = (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 1;
    case (m)
      2'd0: a = rn + 32'(int'(d % 16) * mult);
      2'd1: a = rn + 32'(d);
      2'd2: a = rn + r0;
      default: a = gb + 32'(int'(d % 256) * mult);
    endcase
    f = (s == 2'd3) || (s == 2'd1 && (a % 2) != 0) || (s == 2'd2 && (a % 4) != 0);
    return {f, a};
  endfunction

  always @(posedge clk) begin
    bit [32:0] r;
    started <= 1;
    if (rst) m_valid <= 0;
    else if (in_valid && (!m_valid || out_ready)) begin
      r = ref_ea(in_mode, in_size, in_base, in_index, in_gbase, in_disp);
      m_valid <= 1; m_addr <= r[31:0]; m_fault <= r[32]; m_tag <= cur_tag;
    end else if (out_ready) m_valid <= 0;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (started && !finished) begin
      chk(rst ? "R11" : "R10", "out_valid", 32'(out_valid), 32'(m_valid));
      chk("R10", "in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
      if (m_valid && out_valid === 1'b1) begin
        chk(m_tag, "out_addr", out_addr, m_addr);
        chk(m_tag, "out_fault", 32'(out_fault), 32'(m_fault));
      end
    end
  end

  always @(negedge clk) if (rnd_ready) out_ready <= 1'($urandom % 2);

  task automatic put(string tag, bit [1:0] m, bit [1:0] s, bit [31:0] rn,
                     bit [31:0] r0, bit [31:0] gb, bit [11:0] d);
    @(negedge clk);
    cur_tag = tag; in_valid = 1; in_mode = m; in_size = s;
    in_base = rn; in_index = r0; in_gbase = gb; in_disp = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // directed cases, consumer always ready
    put("R1", 2'd0, 2'd0, 32'h0000_1000, 32'h5, 32'h9, 12'h005);
    put("R2", 2'd0, 2'd1, 32'h0000_1000, 32'h5, 32'h9, 12'h007);
    put("R2", 2'd0, 2'd2, 32'h0000_0100, 32'h5, 32'h9, 12'h00F);
    put("R2", 2'd3, 2'd2, 32'hDEAD_0000, 32'h5, 32'h2000_0000, 12'h010);
    put("R3", 2'd1, 2'd2, 32'h0000_1000, 32'h5, 32'h9, 12'h123);
    put("R3", 2'd1, 2'd0, 32'h0000_1000, 32'h5, 32'h9, 12'hFFF);
    put("R4", 2'd2, 2'd2, 32'h0000_4000, 32'h0000_0040, 32'h9, 12'hFFF);
    put("R5", 2'd3, 2'd1, 32'hFFFF_FFFF, 32'h5, 32'h3000_0000, 12'h0FF);
    put("R6", 2'd0, 2'd0, 32'h0000_2000, 32'h5, 32'h9, 12'hFFF);
    put("R6", 2'd3, 2'd0, 32'h0, 32'h5, 32'h0000_1000, 12'hAFF);
    put("R6", 2'd0, 2'd2, 32'h0000_2000, 32'h5, 32'h9, 12'hFF0);
    put("R7", 2'd2, 2'd0, 32'hFFFF_FFF0, 32'h0000_0020, 32'h9, 12'h0);
    put("R7", 2'd1, 2'd0, 32'hFFFF_FF00, 32'h5, 32'h9, 12'h800);
    put("R8", 2'd1, 2'd3, 32'h0000_1000, 32'h5, 32'h9, 12'h0);
    put("R9", 2'd0, 2'd1, 32'h0000_0001, 32'h5, 32'h9, 12'h0);
    put("R9", 2'd2, 2'd2, 32'h0000_0002, 32'h0, 32'h9, 12'h0);
    put("R9", 2'd2, 2'd2, 32'h0000_0004, 32'h0, 32'h9, 12'h0);
    put("R9", 2'd3, 2'd1, 32'h0, 32'h5, 32'h0000_0101, 12'h001);
    // stall then reset while a result is held
    @(negedge clk); out_ready = 0;
    put("R10", 2'd0, 2'd0, 32'h40, 32'h0, 32'h0, 12'h3);
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0; out_ready = 1;
    @(negedge clk);
    // back-to-back stream with random back-pressure
    rnd_ready = 1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cur_tag  = "R10";
      in_valid = 1'($urandom % 4 != 0);
      in_mode  = 2'($urandom); in_size = 2'($urandom);
      in_base  = $urandom; in_index = $urandom; in_gbase = $urandom;
      in_disp  = 12'($urandom);
    end
    @(negedge clk); in_valid = 0; rnd_ready = 0;
    @(negedge clk); out_ready = 1;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule